// File: doc/BRIEF.md
# Inverted 8E2 Radio-Control Frame Receiver

This block listens to an inverted asynchronous serial line that carries fixed-length radio-control frames, and turns it into validated 25-byte frames. Each character has one start bit, eight data bits sent least significant bit first, an even parity bit and two stop bits. The line is inverted, so the wire rests low when idle. The bit period is set by a clock-divider parameter. At the nominal 100 kbaud on a 100 MHz clock the divider is 1000 and the default idle threshold is 25000 clocks, which is 250 µs.

A frame is only taken in after the line has been quiet for a threshold longer than two character times. Frames normally come every 7 ms or 14 ms with a silent stretch between them, so the receiver locks onto the start of a frame without trusting any byte value alone. The receiver then checks parity and stop bits on every character, and checks the fixed first and last bytes. Any fault raises a lost-frame flag and drops the receiver back to hunting for the next quiet gap. Accepted bytes stream out with their position in the frame. They are also kept in a frame buffer that can be read with one clock of latency. A one-cycle strobe and a frame counter mark each complete, valid frame.

Top module: `rc_frame_rx`

## Requirements
- R1: The wire is inverted: it is low when idle, and every logical bit is the complement of the wire level (a start bit is a high wire).
- R2: Each character is one start bit, eight data bits least significant bit first, one parity bit and two stop bits, each bit lasting CLK_DIV clocks.
- R3: A frame is accepted only if the wire has stayed low for IDLE_CYCLES consecutive clocks before its first byte. Any high level restarts that count, and bytes that arrive without such a gap are ignored.
- R4: A frame is FRAME_BYTES (25) bytes. Position 0 must hold 0x0F and position 24 must hold 0x00. When position 24 is accepted, frame_valid pulses high for one clock and frame_count increments by one in that same clock.
- R5: A parity error (the ones in the eight data bits plus the parity bit add up to an odd count) sets lost_frame, abandons the frame and returns to waiting for an idle gap.
- R6: A stop bit sampled as logical 0 (wire high) is a framing error, handled exactly like a parity error.
- R7: A wrong value at position 0 or position 24 sets lost_frame and returns to waiting for an idle gap; that byte is not emitted.
- R8: Reset clears lost_frame, frame_count and all strobes. Once set, lost_frame stays high until the next valid frame clears it.
- R9: Each byte that passes its checks is emitted on byte_data with a one-clock byte_valid pulse, and byte_idx gives its position, 0 to 24, in order.
- R10: rd_data returns the buffered byte at rd_addr one clock after the address is presented. After a valid frame, addresses 0 to 24 hold that frame.
- R11: An idle gap that completes while a frame is only partly received sets lost_frame, and that same gap arms the receiver for the frame that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_wire | input | 1 | Inverted serial line, low when idle |
| rd_addr | input | 5 | Frame buffer read address |
| rd_data | output | 8 | Frame buffer read data, one clock after the address |
| byte_data | output | 8 | Accepted byte |
| byte_valid | output | 1 | One-clock strobe for byte_data |
| byte_idx | output | 5 | Position of byte_data within the frame |
| frame_valid | output | 1 | One-clock strobe marking a complete, valid frame |
| lost_frame | output | 1 | Set on any frame fault, cleared by a valid frame |
| frame_count | output | 16 | Count of valid frames |

## Verification
On every cycle the assertions check several properties. The frame counter moves only with the frame strobe, and by exactly one. The strobe always coincides with the last byte position and a clear lost flag. Emitted positions stay inside the frame. The character-done pulse lasts a single clock. The gap detector reports a completed gap only after a quiet line. Whether the right bytes come out, and whether each kind of fault is detected, is shown only by the bench's scenarios. These are: random payloads, corrupted header, footer, parity and stop bits, truncated frames, frames sent without a preceding gap, and gaps broken by stray activity.

// File: rtl/rcfr_pkg.sv
package rcfr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_BITS
  } rx_phase_t;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_ARMED,
    ST_RECV
  } asm_state_t;

  typedef struct packed {
    logic [7:0] data;
    logic       par_err;
    logic       stop_err;
  } rx_char_t;

endpackage

// File: rtl/rcfr_char_rx.sv
module rcfr_char_rx
  import rcfr_pkg::*;
#(
  parameter int CLK_DIV = 1000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     rx_wire,
  output logic     line_idle_o,
  output logic     done_o,
  output rx_char_t char_o
);

  localparam int CW   = $clog2(CLK_DIV + 1);
  localparam int HALF = CLK_DIV / 2;

  logic [1:0]  sync_q;
  logic        lvl;
  rx_phase_t   ph_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]  bitn_q;
  logic [7:0]  shreg_q;
  logic        par_q;
  logic        stop1_q;

  // wire is inverted: logical level is the complement
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b00;
    else     sync_q <= {sync_q[0], rx_wire};
  end

  assign lvl         = ~sync_q[1];
  assign line_idle_o = lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      stop1_q <= 1'b0;
      done_o  <= 1'b0;
      char_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          if (!lvl) begin
            ph_q  <= PH_START;
            cnt_q <= CW'(HALF - 1);
          end
        end
        PH_START: begin
          if (cnt_q == '0) begin
            if (!lvl) begin
              ph_q   <= PH_BITS;
              cnt_q  <= CW'(CLK_DIV - 1);
              bitn_q <= '0;
            end else begin
              ph_q <= PH_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_BITS: begin
          if (cnt_q == '0) begin
            cnt_q  <= CW'(CLK_DIV - 1);
            bitn_q <= bitn_q + 1'b1;
            if (bitn_q < 4'd8) begin
              shreg_q <= {lvl, shreg_q[7:1]};
            end else if (bitn_q == 4'd8) begin
              par_q <= lvl;
            end else if (bitn_q == 4'd9) begin
              stop1_q <= lvl;
            end else begin
              done_o          <= 1'b1;
              char_o.data     <= shreg_q;
              char_o.par_err  <= ^{shreg_q, par_q};
              char_o.stop_err <= !(stop1_q && lvl);
              ph_q            <= PH_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/rcfr_gap_det.sv
module rcfr_gap_det #(
  parameter int IDLE_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic line_idle_i,
  output logic gap_met_o,
  output logic gap_hit_o
);

  localparam int GW = $clog2(IDLE_CYCLES + 1);
  localparam logic [GW-1:0] LIMIT = GW'(IDLE_CYCLES);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !line_idle_i) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) gap_hit_o <= 1'b0;
    else     gap_hit_o <= line_idle_i && (cnt_q == LIMIT - 1'b1);
  end

  assign gap_met_o = (cnt_q == LIMIT);

  // R3
  gap_hit_chk: assert property (@(posedge clk) disable iff (rst)
    gap_hit_o |-> gap_met_o);

  // R3
  gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    gap_met_o |-> $past(line_idle_i));

endmodule

// File: rtl/rcfr_frame_asm.sv
module rcfr_frame_asm
  import rcfr_pkg::*;
#(
  parameter int         FRAME_BYTES = 25,
  parameter logic [7:0] HDR_BYTE    = 8'h0F,
  parameter logic [7:0] FTR_BYTE    = 8'h00,
  parameter int         CNT_W       = 16,
  localparam int        IW          = $clog2(FRAME_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             char_done_i,
  input  rx_char_t         char_i,
  input  logic             gap_met_i,
  input  logic             gap_hit_i,
  input  logic [IW-1:0]    rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic [7:0]       byte_data_o,
  output logic             byte_valid_o,
  output logic [IW-1:0]    byte_idx_o,
  output logic             frame_valid_o,
  output logic             lost_o,
  output logic [CNT_W-1:0] frame_count_o
);

  localparam logic [IW-1:0] LAST = IW'(FRAME_BYTES - 1);

  asm_state_t  st_q;
  logic [IW-1:0] idx_q;
  logic [7:0]  mem [FRAME_BYTES];

  logic char_bad, fixed_bad, live, accept, reject, trunc;

  always_comb begin
    char_bad  = char_i.par_err || char_i.stop_err;
    fixed_bad = ((idx_q == '0) && (char_i.data != HDR_BYTE)) ||
                ((idx_q == LAST) && (char_i.data != FTR_BYTE));
    live      = (st_q != ST_HUNT);
    accept    = char_done_i && live && !char_bad && !fixed_bad;
    reject    = char_done_i && live && (char_bad || fixed_bad);
    trunc     = gap_hit_i && (st_q == ST_RECV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_HUNT;
      idx_q         <= '0;
      byte_data_o   <= '0;
      byte_valid_o  <= 1'b0;
      byte_idx_o    <= '0;
      frame_valid_o <= 1'b0;
      lost_o        <= 1'b0;
      frame_count_o <= '0;
    end else begin
      byte_valid_o  <= 1'b0;
      frame_valid_o <= 1'b0;
      case (st_q)
        ST_HUNT: begin
          idx_q <= '0;
          if (gap_met_i) st_q <= ST_ARMED;
        end
        default: begin
          if (trunc) begin
            lost_o <= 1'b1;
            idx_q  <= '0;
            st_q   <= ST_ARMED;
          end else if (reject) begin
            lost_o <= 1'b1;
            idx_q  <= '0;
            st_q   <= ST_HUNT;
          end else if (accept) begin
            byte_valid_o <= 1'b1;
            byte_data_o  <= char_i.data;
            byte_idx_o   <= idx_q;
            if (idx_q == LAST) begin
              frame_valid_o <= 1'b1;
              frame_count_o <= frame_count_o + 1'b1;
              lost_o        <= 1'b0;
              idx_q         <= '0;
              st_q          <= ST_HUNT;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_RECV;
            end
          end
        end
      endcase
    end
  end

  // frame buffer, simple dual port for block RAM inference
  always_ff @(posedge clk) begin
    if (accept) mem[idx_q] <= char_i.data;
    rd_data_o <= mem[rd_addr_i];
  end

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |-> (frame_count_o == $past(frame_count_o) + 1'b1));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_valid_o |-> $stable(frame_count_o));

  // R4
  frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |-> (byte_valid_o && byte_idx_o == LAST));

  // R8
  valid_clears_lost_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |-> !lost_o);

  // R9
  byte_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> (byte_idx_o <= LAST));

endmodule

// File: rtl/rc_frame_rx.sv
module rc_frame_rx
  import rcfr_pkg::*;
#(
  parameter int         CLK_DIV     = 1000,
  parameter int         IDLE_CYCLES = 25000,
  parameter int         FRAME_BYTES = 25,
  parameter logic [7:0] HDR_BYTE    = 8'h0F,
  parameter logic [7:0] FTR_BYTE    = 8'h00,
  parameter int         CNT_W       = 16,
  localparam int        IW          = $clog2(FRAME_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_wire,
  input  logic [IW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic [7:0]       byte_data,
  output logic             byte_valid,
  output logic [IW-1:0]    byte_idx,
  output logic             frame_valid,
  output logic             lost_frame,
  output logic [CNT_W-1:0] frame_count
);

  logic     line_idle;
  logic     char_done;
  rx_char_t char_w;
  logic     gap_met;
  logic     gap_hit;

  rcfr_char_rx #(.CLK_DIV(CLK_DIV)) u_char (
    .clk        (clk),
    .rst        (rst),
    .rx_wire    (rx_wire),
    .line_idle_o(line_idle),
    .done_o     (char_done),
    .char_o     (char_w)
  );

  rcfr_gap_det #(.IDLE_CYCLES(IDLE_CYCLES)) u_gap (
    .clk        (clk),
    .rst        (rst),
    .line_idle_i(line_idle),
    .gap_met_o  (gap_met),
    .gap_hit_o  (gap_hit)
  );

  rcfr_frame_asm #(
    .FRAME_BYTES(FRAME_BYTES),
    .HDR_BYTE   (HDR_BYTE),
    .FTR_BYTE   (FTR_BYTE),
    .CNT_W      (CNT_W)
  ) u_asm (
    .clk          (clk),
    .rst          (rst),
    .char_done_i  (char_done),
    .char_i       (char_w),
    .gap_met_i    (gap_met),
    .gap_hit_i    (gap_hit),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .byte_data_o  (byte_data),
    .byte_valid_o (byte_valid),
    .byte_idx_o   (byte_idx),
    .frame_valid_o(frame_valid),
    .lost_o       (lost_frame),
    .frame_count_o(frame_count)
  );

endmodule

// File: tb/test_rc_frame_rx.sv
module test_rc_frame_rx;

  localparam int CD   = 8;
  localparam int IDLE = 240;
  localparam int LONG_GAP  = 300;
  localparam int SHORT_GAP = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_wire = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [7:0]  byte_data;
  logic        byte_valid;
  logic [4:0]  byte_idx;
  logic        frame_valid;
  logic        lost_frame;
  logic [15:0] frame_count;

  int total = 0;
  int bad   = 0;
  int fv_cnt = 0;
  int bv_cnt = 0;
  int exp_count = 0;
  logic [7:0] fr [25];
  logic [7:0] seen [25];

  always #5 clk = ~clk;

  rc_frame_rx #(.CLK_DIV(CD), .IDLE_CYCLES(IDLE)) i_rc_frame_rx (
    .clk(clk), .rst(rst), .rx_wire(rx_wire), .rd_addr(rd_addr),
    .rd_data(rd_data), .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_idx(byte_idx), .frame_valid(frame_valid), .lost_frame(lost_frame),
    .frame_count(frame_count)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (frame_valid) fv_cnt++;
      if (byte_valid) begin
        bv_cnt++;
        seen[byte_idx] = byte_data;
      end
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_wire = v;
    repeat (n) @(negedge clk);
  endtask

  // logical bit b, sent inverted on the wire (R1)
  task automatic bit_out(input logic b);
    hold(~b, CD);
  endtask

  task automatic send_char(input logic [7:0] b, input logic flip_par, input logic kill_stop);
    bit_out(1'b0);
    for (int k = 0; k < 8; k++) bit_out(b[k]);
    bit_out((^b) ^ flip_par);
    bit_out(!kill_stop);
    bit_out(1'b1);
    hold(1'b0, CD * ($urandom % 3));
  endtask

  task automatic send_bytes(input int n, input int perr, input int serr);
    for (int k = 0; k < n; k++) send_char(fr[k], k == perr, k == serr);
  endtask

  task automatic new_payload();
    for (int k = 0; k < 25; k++) fr[k] = 8'($urandom);
    fr[0]  = 8'h0F;
    fr[24] = 8'h00;
  endtask

  task automatic check_stream(input string req);
    int mism = 0;
    for (int k = 0; k < 25; k++) if (seen[k] !== fr[k]) mism++;
    chk(req, mism, 0);
  endtask

  task automatic check_buf(input string req);
    int mism = 0;
    for (int a = 0; a < 25; a++) begin
      rd_addr = 5'(a);
      @(negedge clk);
      if (rd_data !== fr[a]) mism++;
    end
    chk(req, mism, 0);
  endtask

  // sends one frame of a given kind after a long gap and checks the result
  // kind: 0 good, 1 bad header, 2 bad footer, 3 parity, 4 stop
  task automatic run_frame(input int kind);
    int fv0, bv0, pos, exp_bv, exp_fv;
    new_payload();
    pos = 1 + ($urandom % 23);
    fv0 = fv_cnt;
    bv0 = bv_cnt;
    exp_fv = 0;
    case (kind)
      0: begin exp_bv = 25; exp_fv = 1; end
      1: begin fr[0] = 8'h0F ^ (8'h01 << ($urandom % 8)); exp_bv = 0; end
      2: begin fr[24] = 8'h01 << ($urandom % 8); exp_bv = 24; end
      3: exp_bv = pos;
      default: exp_bv = pos;
    endcase
    send_bytes(25, (kind == 3) ? pos : -1, (kind == 4) ? pos : -1);
    repeat (20) @(negedge clk);
    exp_count += exp_fv;
    case (kind)
      0: begin
        chk("R4 frame strobe", fv_cnt - fv0, 1);
        chk("R9 bytes emitted", bv_cnt - bv0, 25);
        chk("R8 lost cleared", int'(lost_frame), 0);
        check_stream("R1 R2 R9 byte stream");
      end
      1: begin
        chk("R7 header fault strobe", fv_cnt - fv0, 0);
        chk("R7 header fault lost", int'(lost_frame), 1);
        chk("R7 header byte not emitted", bv_cnt - bv0, exp_bv);
      end
      2: begin
        chk("R7 footer fault lost", int'(lost_frame), 1);
        chk("R7 footer byte not emitted", bv_cnt - bv0, exp_bv);
      end
      3: begin
        chk("R5 parity fault lost", int'(lost_frame), 1);
        chk("R5 parity fault bytes", bv_cnt - bv0, exp_bv);
      end
      default: begin
        chk("R6 stop fault lost", int'(lost_frame), 1);
        chk("R6 stop fault bytes", bv_cnt - bv0, exp_bv);
      end
    endcase
    chk("R4 frame count", int'(frame_count), exp_count);
    hold(1'b0, LONG_GAP);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int fv0, bv0;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8 reset lost", int'(lost_frame), 0);
    chk("R8 reset count", int'(frame_count), 0);
    chk("R8 reset strobes", int'(frame_valid) + int'(byte_valid), 0);
    hold(1'b0, LONG_GAP);

    // good frame, buffer content (R10)
    run_frame(0);
    check_buf("R10 buffer after frame");

    run_frame(1);
    run_frame(0);
    run_frame(2);
    run_frame(3);
    run_frame(0);
    run_frame(4);
    run_frame(0);
    check_buf("R10 buffer after later frame");

    // R11 truncated frame, gap reused for next frame
    new_payload();
    bv0 = bv_cnt;
    fv0 = fv_cnt;
    send_bytes(12, -1, -1);
    hold(1'b0, LONG_GAP);
    chk("R11 truncated lost", int'(lost_frame), 1);
    chk("R11 truncated no strobe", fv_cnt - fv0, 0);
    chk("R11 truncated bytes", bv_cnt - bv0, 12);
    new_payload();
    send_bytes(25, -1, -1);
    repeat (20) @(negedge clk);
    exp_count++;
    chk("R11 frame after gap", fv_cnt - fv0, 1);
    chk("R11 lost cleared", int'(lost_frame), 0);

    // R3 frame without preceding gap is ignored
    hold(1'b0, SHORT_GAP);
    new_payload();
    fv0 = fv_cnt;
    bv0 = bv_cnt;
    send_bytes(25, -1, -1);
    repeat (20) @(negedge clk);
    chk("R3 no gap no frame", fv_cnt - fv0, 0);
    chk("R3 no gap no bytes", bv_cnt - bv0, 0);

    // R3 activity restarts the idle timer
    hold(1'b0, 150);
    send_char(8'hFF, 1'b0, 1'b0);
    hold(1'b0, 150);
    new_payload();
    send_bytes(25, -1, -1);
    repeat (20) @(negedge clk);
    chk("R3 broken gap no frame", fv_cnt - fv0, 0);
    chk("R3 count unchanged", int'(frame_count), exp_count);
    hold(1'b0, LONG_GAP);
    run_frame(0);

    // random mix
    for (int n = 0; n < 8; n++) run_frame(int'($urandom % 5));

    finish_run();
  end

endmodule